// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to 32 level-style interrupt sources onto a single registered request line for a processor core. Index 0 is reserved as the "none" vector, so real sources are numbered 1 to 31. Sources 1 to 4 are the four high-rate serial channels. A static layout bit decides whether those four take the top of the fixed priority table ("grouped") or sit at regular intervals through it ("spread"). A run-time override register names one source that outranks every other source.

Each source has a pending bit, a mask bit and an in-service bit. When the core raises the acknowledge strobe, the block latches the vector of the best eligible source. It then clears that source's pending bit and sets its in-service bit. While any in-service bit is set, only strictly higher-priority sources can raise the request again, so handlers nest. Software drives the block through a small write port. The address selects configuration, mask, pending-clear or in-service-clear. The pending and in-service vectors are visible on output ports so that software can poll them.

Top module: `prio_nest_intc`

## Requirements
- R1: A source i (1..31) that is high at a clock edge sets pending bit i at that edge, whatever its mask. Source 0 never sets a pending bit.
- R2: `irq_o` is registered. It is high in the cycle after the block is enabled and has at least one pending, unmasked source that outranks every in-service source. When no pending source is unmasked, `irq_o` stays low (polling mode).
- R3: With the layout bit set to 1 (grouped), priority follows the source index, and source 1 is the highest.
- R4: With the layout bit set to 0 (spread), serial sources 1, 2, 3 and 4 take table positions 0, 8, 16 and 24. The other sources fill the remaining positions in ascending index order, so source 6 outranks source 2 and source 12 outranks source 3.
- R5: A nonzero override value v in configuration bits [12:8] makes source v the highest priority in either layout. The value 0 disables the override. The override may be rewritten while enabled.
- R6: An acknowledge while enabled latches the winning vector on `vec_o`, clears that source's pending bit and sets its in-service bit, all at the same edge.
- R7: While a source is in service, pending sources of equal or lower priority neither raise `irq_o` nor win an acknowledge. They stay pending until the blocking in-service bit is cleared.
- R8: Writing 1 at address 2 clears the matching pending bits, and writing 1 at address 3 clears the matching in-service bits. Zero bits have no effect. A source that is high in the same cycle as a pending clear keeps its pending bit set.
- R9: An acknowledge with no eligible source latches vector 0 and leaves every in-service bit unchanged.
- R10: A write at address 0 sets the enable bit (bit 0) and the layout bit (bit 1). The layout bit is taken only when the block was disabled before that write. While the block is disabled, `irq_o` is low and acknowledge has no effect.
- R11: After reset the block is disabled with layout spread, override 0, all masks 0 and all pending and in-service bits 0. `irq_o` and `vec_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level interrupt sources, bit 0 unused |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 config, 1 mask, 2 pending clear, 3 in-service clear |
| wr_data_i | input | NUM_SRC | Write data |
| ack_i | input | 1 | Acknowledge strobe from the core |
| irq_o | output | 1 | Registered interrupt request |
| vec_o | output | VEC_W | Vector latched at the last acknowledge |
| pend_o | output | NUM_SRC | Pending bits |
| insv_o | output | NUM_SRC | In-service bits |

## Verification
The bench builds the block with its defaults: 32 sources, a 5-bit vector and four serial channels, so the spread step is 8. These values make the full priority table reachable. They also place source 6 above source 2 only in the spread layout, which gives an acknowledge order that tells the two layouts apart. With 31 real sources the override can reach any table position, including one far below the serial channels, and that exposes nesting against an override in service.

// File: rtl/pnic_pkg.sv
package pnic_pkg;

   typedef enum logic [1:0] {
      ADDR_CFG  = 2'd0,
      ADDR_MASK = 2'd1,
      ADDR_PCLR = 2'd2,
      ADDR_ICLR = 2'd3
   } reg_addr_e;

   localparam int CFG_EN_BIT  = 0;
   localparam int CFG_GRP_BIT = 1;
   localparam int CFG_HP_LSB  = 8;

   // table position of source s when serial channels are at the top
   function automatic int pos_grouped(input int s);
      return s - 1;
   endfunction

   // table position of source s when serial channels are spread
   function automatic int pos_spread(input int s, input int nsrc, input int nhs);
      int step;
      int j;
      step = nsrc / nhs;
      if (s >= 1 && s <= nhs) return (s - 1) * step;
      j = s - 1 - nhs;
      return j + j / (step - 1) + 1;
   endfunction

endpackage

// File: rtl/pnic_rank_map.sv
module pnic_rank_map #(
   parameter int NUM_SRC = 32,
   parameter int VEC_W   = 5,
   parameter int NUM_HS  = 4,
   parameter int KEY_W   = VEC_W + 1
) (
   input  logic                            grouped_i,
   input  logic [VEC_W-1:0]                hp_src_i,
   output logic [NUM_SRC-1:0][KEY_W-1:0]   key_o
);
   import pnic_pkg::*;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_key
      if (i == 0) begin : g_none
         assign key_o[i] = '1;
      end else begin : g_real
         localparam int RG = pos_grouped(i);
         localparam int RS = pos_spread(i, NUM_SRC, NUM_HS);
         logic [KEY_W-1:0] base_key;
         assign base_key = grouped_i ? KEY_W'(RG + 1) : KEY_W'(RS + 1);
         assign key_o[i] = (hp_src_i == VEC_W'(i)) ? '0 : base_key;
      end
   end

endmodule

// File: rtl/pnic_arbiter.sv
module pnic_arbiter #(
   parameter int NUM_SRC = 32,
   parameter int VEC_W   = 5,
   parameter int KEY_W   = VEC_W + 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_SRC-1:0]              req_i,
   input  logic [NUM_SRC-1:0][KEY_W-1:0]   key_i,
   output logic                            valid_o,
   output logic [VEC_W-1:0]                idx_o,
   output logic [KEY_W-1:0]                key_o
);

   always_comb begin
      idx_o = '0;
      key_o = '1;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_i[i] && (key_i[i] < key_o)) begin
            key_o = key_i[i];
            idx_o = VEC_W'(i);
         end
      end
   end

   assign valid_o = |req_i;

   // R6
   win_is_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> req_i[idx_o]);

   // R9
   idle_no_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (idx_o == '0));

endmodule

// File: rtl/pnic_src_bank.sv
module pnic_src_bank #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               mask_we_i,
   input  logic [NUM_SRC-1:0] mask_d_i,
   input  logic [NUM_SRC-1:0] pend_clr_i,
   input  logic [NUM_SRC-1:0] insv_clr_i,
   input  logic [NUM_SRC-1:0] ack_set_i,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] insv_o
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == 0) begin : g_rsvd
         assign pend_o[i] = 1'b0;
         assign mask_o[i] = 1'b0;
         assign insv_o[i] = 1'b0;
      end else begin : g_live
         logic pend_q, mask_q, insv_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
               mask_q <= 1'b0;
               insv_q <= 1'b0;
            end else begin
               pend_q <= src_i[i] | (pend_q & ~pend_clr_i[i] & ~ack_set_i[i]);
               insv_q <= ack_set_i[i] | (insv_q & ~insv_clr_i[i]);
               if (mask_we_i) mask_q <= mask_d_i[i];
            end
         end
         assign pend_o[i] = pend_q;
         assign mask_o[i] = mask_q;
         assign insv_o[i] = insv_q;

         // R8
         event_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            src_i[i] |=> pend_q);
      end
   end

endmodule

// File: rtl/prio_nest_intc.sv
module prio_nest_intc #(
   parameter int NUM_SRC = 32,
   parameter int VEC_W   = 5,
   parameter int NUM_HS  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               wr_en_i,
   input  logic [1:0]         wr_addr_i,
   input  logic [NUM_SRC-1:0] wr_data_i,
   input  logic               ack_i,
   output logic               irq_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] insv_o
);
   import pnic_pkg::*;

   localparam int KEY_W = VEC_W + 1;
   localparam int STEP  = NUM_SRC / NUM_HS;

   if (NUM_SRC != (1 << VEC_W)) begin : g_bad_w
      $error("NUM_SRC must equal 2**VEC_W");
   end
   if (NUM_HS < 1 || STEP < 2 || (NUM_SRC % NUM_HS) != 0) begin : g_bad_hs
      $error("NUM_HS must divide NUM_SRC with a step of at least 2");
   end
   if (CFG_HP_LSB + VEC_W > NUM_SRC) begin : g_bad_cfg
      $error("config field does not fit the write data");
   end

   // configuration
   logic             en_q, grp_q;
   logic [VEC_W-1:0] hp_q;
   logic             cfg_we;

   assign cfg_we = wr_en_i && (wr_addr_i == ADDR_CFG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         grp_q <= 1'b0;
         hp_q  <= '0;
      end else if (cfg_we) begin
         en_q <= wr_data_i[CFG_EN_BIT];
         hp_q <= wr_data_i[CFG_HP_LSB +: VEC_W];
         if (!en_q) grp_q <= wr_data_i[CFG_GRP_BIT];
      end
   end

   // source state
   logic [NUM_SRC-1:0] pend, mask, insv, ack_set, pclr, iclr;

   assign pclr = (wr_en_i && wr_addr_i == ADDR_PCLR) ? wr_data_i : '0;
   assign iclr = (wr_en_i && wr_addr_i == ADDR_ICLR) ? wr_data_i : '0;

   pnic_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_i),
      .mask_we_i  (wr_en_i && wr_addr_i == ADDR_MASK),
      .mask_d_i   (wr_data_i),
      .pend_clr_i (pclr),
      .insv_clr_i (iclr),
      .ack_set_i  (ack_set),
      .pend_o     (pend),
      .mask_o     (mask),
      .insv_o     (insv)
   );

   // priority keys
   logic [NUM_SRC-1:0][KEY_W-1:0] keys;

   pnic_rank_map #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .NUM_HS(NUM_HS), .KEY_W(KEY_W)) u_map (
      .grouped_i (grp_q),
      .hp_src_i  (hp_q),
      .key_o     (keys)
   );

   // arbitration: best requester and best in-service source
   logic             win_v, isr_v;
   logic [VEC_W-1:0] win_idx, isr_idx;
   logic [KEY_W-1:0] win_key, isr_key;
   logic             grant_ok;

   pnic_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .KEY_W(KEY_W)) u_req_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (pend & mask),
      .key_i   (keys),
      .valid_o (win_v),
      .idx_o   (win_idx),
      .key_o   (win_key)
   );

   pnic_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .KEY_W(KEY_W)) u_isr_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (insv),
      .key_i   (keys),
      .valid_o (isr_v),
      .idx_o   (isr_idx),
      .key_o   (isr_key)
   );

   assign grant_ok = win_v && (!isr_v || (win_key < isr_key));
   assign ack_set  = (ack_i && en_q && grant_ok) ? (NUM_SRC'(1) << win_idx) : '0;

   logic             irq_q;
   logic [VEC_W-1:0] vec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         vec_q <= '0;
      end else begin
         irq_q <= en_q && grant_ok;
         if (ack_i && en_q) vec_q <= grant_ok ? win_idx : '0;
      end
   end

   assign irq_o  = irq_q;
   assign vec_o  = vec_q;
   assign pend_o = pend;
   assign insv_o = insv;

   // R6
   ack_sets_insv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && en_q && grant_ok) |=> insv[$past(win_idx)] && (vec_q == $past(win_idx)));

   // R9
   none_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && en_q && !grant_ok && !wr_en_i) |=> (vec_q == '0) && $stable(insv));

   // R2
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & mask) == '0) |=> !irq_q);

   // R10
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> $stable(grp_q));

   // R10
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !irq_q);

   for (genvar i = 1; i < NUM_SRC; i++) begin : g_nest_chk
      // R7
      nest_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (insv[i] && grant_ok) |-> (win_key < keys[i]));
   end

endmodule

// File: tb/sim_prio_nest_intc.sv
module sim_prio_nest_intc;

   localparam int N = 32;
   localparam int VW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [N-1:0]  wr_data = '0;
   logic          ack = 1'b0;
   logic          irq;
   logic [VW-1:0] vec;
   logic [N-1:0]  pend, insv;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prio_nest_intc #(.NUM_SRC(N), .VEC_W(VW), .NUM_HS(4)) u0 (
      .clk (clk), .rst_n (rst_n), .src_i (src),
      .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
      .ack_i (ack), .irq_o (irq), .vec_o (vec), .pend_o (pend), .insv_o (insv)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   function automatic logic [N-1:0] cfg(input bit en, input bit grp, input int hp);
      logic [N-1:0] d;
      d = '0;
      d[0] = en;
      d[1] = grp;
      d[8 +: VW] = VW'(hp);
      return d;
   endfunction

   task automatic pulse(input logic [N-1:0] s);
      src = s;
      @(negedge clk);
      src = '0;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic do_ack(output logic [VW-1:0] v);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      v = vec;
   endtask

   task automatic t_reset();
      chk(32'(irq), 0, "R11 irq");
      chk(32'(vec), 0, "R11 vec");
      chk(pend, 0, "R11 pend");
      chk(insv, 0, "R11 insv");
   endtask

   task automatic t_poll();
      wr(2'd0, cfg(1, 0, 0));
      pulse((N'(1) << 5) | N'(1));
      settle();
      chk(pend, N'(1) << 5, "R1 pending set masked, src0 ignored");
      chk(32'(irq), 0, "R2 masked source quiet");
      wr(2'd2, '0);
      chk(pend, N'(1) << 5, "R8 zero write keeps pending");
      wr(2'd2, N'(1) << 5);
      chk(pend, 0, "R8 W1C pending");
      wr(2'd1, '1);
   endtask

   task automatic t_spread();
      logic [VW-1:0] v;
      pulse((N'(1) << 2) | (N'(1) << 6) | (N'(1) << 12) | (N'(1) << 3));
      settle();
      chk(32'(irq), 1, "R2 irq raised");
      do_ack(v); chk(32'(v), 6, "R4 first spread");
      chk(insv, N'(1) << 6, "R6 insv set");
      chk(pend[6], 0, "R6 pending cleared");
      wr(2'd3, N'(1) << 6);
      do_ack(v); chk(32'(v), 2, "R4 second spread"); wr(2'd3, N'(1) << 2);
      do_ack(v); chk(32'(v), 12, "R4 third spread"); wr(2'd3, N'(1) << 12);
      do_ack(v); chk(32'(v), 3, "R4 fourth spread"); wr(2'd3, N'(1) << 3);
      chk(insv, 0, "R8 W1C in-service");
   endtask

   task automatic t_grouped();
      logic [VW-1:0] v;
      wr(2'd0, cfg(0, 1, 0));
      wr(2'd0, cfg(1, 1, 0));
      pulse((N'(1) << 20) | (N'(1) << 9) | (N'(1) << 3));
      settle();
      do_ack(v); chk(32'(v), 3, "R3 grouped first"); wr(2'd3, N'(1) << 3);
      do_ack(v); chk(32'(v), 9, "R3 grouped second"); wr(2'd3, N'(1) << 9);
      do_ack(v); chk(32'(v), 20, "R3 grouped third"); wr(2'd3, N'(1) << 20);
   endtask

   task automatic t_override();
      logic [VW-1:0] v;
      wr(2'd0, cfg(1, 1, 25));
      pulse((N'(1) << 2) | (N'(1) << 25));
      settle();
      do_ack(v); chk(32'(v), 25, "R5 override wins");
      settle();
      chk(32'(irq), 0, "R7 override in service blocks source 2");
      wr(2'd3, N'(1) << 25);
      do_ack(v); chk(32'(v), 2, "R5 source 2 after override");
      wr(2'd3, N'(1) << 2);
      wr(2'd0, cfg(1, 1, 0));
   endtask

   task automatic t_nest();
      logic [VW-1:0] v;
      pulse(N'(1) << 10);
      settle();
      do_ack(v); chk(32'(v), 10, "R6 vector 10");
      pulse(N'(1) << 15);
      settle();
      chk(32'(irq), 0, "R7 lower source blocked");
      chk(pend, N'(1) << 15, "R7 lower source stays pending");
      do_ack(v); chk(32'(v), 0, "R9 none vector");
      chk(insv, N'(1) << 10, "R9 in-service unchanged");
      pulse(N'(1) << 4);
      settle();
      chk(32'(irq), 1, "R7 higher source nests");
      do_ack(v); chk(32'(v), 4, "R7 nested vector");
      chk(insv, (N'(1) << 4) | (N'(1) << 10), "R7 both in service");
      wr(2'd3, N'(1) << 4);
      settle();
      chk(32'(irq), 0, "R7 still blocked by 10");
      wr(2'd3, N'(1) << 10);
      settle();
      chk(32'(irq), 1, "R7 released");
      do_ack(v); chk(32'(v), 15, "R7 released vector");
      wr(2'd3, N'(1) << 15);
   endtask

   task automatic t_race();
      src = N'(1) << 7;
      wr(2'd2, N'(1) << 7);
      src = '0;
      chk(pend, N'(1) << 7, "R8 event beats clear");
      wr(2'd2, N'(1) << 7);
      chk(pend, 0, "R8 later clear");
   endtask

   task automatic t_mode_lock();
      logic [VW-1:0] v;
      wr(2'd0, cfg(1, 0, 0));
      pulse((N'(1) << 2) | (N'(1) << 6));
      settle();
      do_ack(v); chk(32'(v), 2, "R10 layout held while enabled");
      wr(2'd3, N'(1) << 2);
      do_ack(v); chk(32'(v), 6, "R10 next vector");
      wr(2'd3, N'(1) << 6);
      wr(2'd0, cfg(0, 0, 0));
      pulse(N'(1) << 3);
      settle();
      chk(32'(irq), 0, "R10 disabled irq low");
      do_ack(v); chk(32'(v), 6, "R10 disabled ack ignored");
      chk(pend, N'(1) << 3, "R10 disabled ack keeps pending");
      chk(insv, 0, "R10 disabled ack no in-service");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_poll();
      t_spread();
      t_grouped();
      t_override();
      t_nest();
      t_race();
      t_mode_lock();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule